// File: doc/BRIEF.md
# Dual-Output Edge-Aligned PWM Generator with Per-Event Action Tables

This block produces two pulse-width-modulated outputs, A and B, from one up-counting time base. The counter steps from zero up to a programmable terminal value and then returns to zero, so one PWM cycle lasts (terminal value + 1) counter ticks. Each output has its own compare register and its own small action table. The table says what the output does when the counter sits at zero and what it does when the counter equals that output's compare value: nothing, drive low, drive high or invert.

The period and both compare values are written through a simple synchronous write port into shadow copies. The working copies pick up the shadow values only when the counter returns to zero, so every PWM cycle runs with one consistent set of values. Each compare can also be switched to immediate loading. A run enable stops the time base for configuration and restarts it from zero. Two cascaded power-of-two prescalers set the tick rate. A one-cycle sync pulse marks each zero crossing for downstream blocks.

Top module: `pwm_aq_gen`

## Requirements
- R1: While running, the counter advances by one on each tick and returns to 0 on the tick after it equals the active period. It never exceeds the active period. `cnt_o` shows the counter.
- R2: Each event's action code is 2 bits: 00 leaves the output unchanged, 01 drives it low, 10 drives it high, 11 inverts it. The zero event fires on a tick while the counter is 0. The compare event fires on a tick while the counter equals the active compare value. The output changes on that same clock edge, and is otherwise unchanged.
- R3: When the zero event and the compare event of one output fire on the same tick, only the compare event's action is applied.
- R4: A compare write goes to the shadow copy, and the active copy takes it on the tick that returns the counter to 0. If the output's immediate bit is set, the active copy takes the written value on the write's clock edge.
- R5: A period write takes effect only when the counter next returns to 0. The cycle in progress ends at the old period.
- R6: While `tb_en` is low, the counter is held at 0, the outputs keep their values and the active copies follow the shadows. The first tick after `tb_en` rises is a zero event.
- R7: `sync_o` is high for exactly the one clock cycle after each zero event, and low at all other times.
- R8: A compare value greater than the period never matches, so that output keeps the level set by its zero event.
- R9: The tick rate is the clock divided by 2^(d1+d2). d1 is control bits [3:2], d2 is control bits [5:4], and with both at 0 there is a tick on every clock while running.
- R10: Write addresses: 0 sets the period, 1 sets compare A, 2 sets compare B, 3 sets the action table of A, 4 sets the action table of B, and 5 sets the control register. In an action table, bits [1:0] are the zero-event code and bits [3:2] are the compare-event code. In the control register, bit 0 is A's immediate bit and bit 1 is B's immediate bit.
- R11: After reset, the counter, both outputs, `sync_o` and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Time-base run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| cnt_o | output | W | Current counter value |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| sync_o | output | 1 | One-cycle pulse after each zero event |

## Verification
On every cycle, the assertions check:
- that the counter stays within the active period, steps by one and is held at zero while disabled;
- that active period and compare values change only at the wrap or on an immediate write;
- that outputs are stable between ticks;
- that the compare event wins a tie;
- that each sync pulse follows a zero event.

Only the bench scenarios can show the full output waveforms, each compared cycle by cycle with a model built from the requirements. These cover every action code, a compare past the period, shadowed and immediate compare updates, a period change in mid-cycle, the prescaler ratio and the register address decoding.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PRD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] A_ACTA = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;

  // next output level for one action code
  function automatic logic apply_act(logic cur, act_e a);
    case (a)
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // compare event outranks the zero event
  function automatic act_e pick_act(logic zero_hit, logic cmp_hit, act_e za, act_e ca);
    if (cmp_hit) return ca;
    if (zero_hit) return za;
    return ACT_NONE;
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int LOG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_tick,
  input  logic [LOG_W-1:0] div_log2,
  output logic             out_tick
);
  localparam int CW = (1 << LOG_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim      = CW'((1 << div_log2) - 1);
  assign out_tick = en && in_tick && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (in_tick)  cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         prd_wr,
  input  logic [W-1:0] prd_data,
  output logic [W-1:0] cnt,
  output logic         zero_evt,
  output logic         wrap_evt
);
  logic [W-1:0] prd_sh, prd_act;

  assign zero_evt = tick && (cnt == '0);
  assign wrap_evt = tick && (cnt == prd_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_sh  <= '0;
      prd_act <= '0;
      cnt     <= '0;
    end else begin
      if (prd_wr) prd_sh <= prd_data;
      if (!en) begin
        cnt     <= '0;
        prd_act <= prd_sh;
      end else if (wrap_evt) begin
        cnt     <= '0;
        prd_act <= prd_sh;
      end else if (tick) begin
        cnt <= cnt + W'(1);
      end
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt <= prd_act);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !wrap_evt) |=> cnt == $past(cnt) + W'(1));
  // R6
  cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  // R5
  prd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt) |=> $stable(prd_act));
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         zero_evt,
  input  logic         wrap_evt,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_data,
  input  logic         imm,
  input  act_e         act_zero,
  input  act_e         act_cmp,
  output logic         out
);
  logic [W-1:0] cmp_sh, cmp_act;
  logic         cmp_hit;

  assign cmp_hit = tick && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_sh  <= '0;
      cmp_act <= '0;
      out     <= 1'b0;
    end else begin
      if (cmp_wr) cmp_sh <= cmp_data;
      if (imm && cmp_wr)          cmp_act <= cmp_data;
      else if (!en || wrap_evt)   cmp_act <= cmp_sh;
      out <= apply_act(out, pick_act(zero_evt, cmp_hit, act_zero, act_cmp));
    end
  end

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt && !(imm && cmp_wr)) |=> $stable(cmp_act));
  // R3
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && cmp_hit && act_cmp == ACT_CLR) |=> !out);
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out));
endmodule

// File: rtl/pwm_aq_gen.sv
module pwm_aq_gen
  import pwm_aq_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      cnt_o,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              sync_o
);
  localparam int NCH    = 2;
  localparam int NSTG   = 2;
  localparam int CTRL_W = NCH + NSTG * DIV_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [3:0]        act_q [NCH];
  logic [NSTG:0]     tk;
  logic              tick, zero_evt, wrap_evt, sync_q;
  logic [W-1:0]      cnt;
  logic [NCH-1:0]    pwm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int c = 0; c < NCH; c++) act_q[c] <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
      for (int c = 0; c < NCH; c++)
        if (wr_addr == A_ACTA + ADDR_W'(c)) act_q[c] <= wr_data[3:0];
    end
  end

  assign tk[0] = 1'b1;
  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_ps
      pwm_prescale #(.LOG_W(DIV_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .en(tb_en), .in_tick(tk[g]),
        .div_log2(ctrl_q[NCH + g*DIV_W +: DIV_W]), .out_tick(tk[g+1]));
    end
  endgenerate
  assign tick = tk[NSTG];

  pwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(tb_en), .tick(tick),
    .prd_wr(wr_en && wr_addr == A_PRD), .prd_data(wr_data),
    .cnt(cnt), .zero_evt(zero_evt), .wrap_evt(wrap_evt));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwm_aq_chan #(.W(W)) u_ch (
        .clk(clk), .rst_n(rst_n), .en(tb_en), .tick(tick), .cnt(cnt),
        .zero_evt(zero_evt), .wrap_evt(wrap_evt),
        .cmp_wr(wr_en && wr_addr == A_CMPA + ADDR_W'(c)), .cmp_data(wr_data),
        .imm(ctrl_q[c]), .act_zero(act_e'(act_q[c][1:0])),
        .act_cmp(act_e'(act_q[c][3:2])), .out(pwm[c]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= zero_evt;
  end

  assign cnt_o  = cnt;
  assign pwm_a  = pwm[0];
  assign pwm_b  = pwm[1];
  assign sync_o = sync_q;

  // R7
  sync_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> $past(zero_evt));
  // R7
  sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_evt |=> !sync_o);
endmodule

// File: tb/sim_pwm_aq_gen.sv
module sim_pwm_aq_gen;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, tb_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic pwm_a, pwm_b, sync_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model, built from the requirements
  int m_cnt = 0, m_prd = 0, m_prd_p = 0;
  int m_cmp [2] = '{0, 0};
  int m_cmp_p [2] = '{0, 0};
  logic [1:0] m_za [2] = '{2'b00, 2'b00};
  logic [1:0] m_ca [2] = '{2'b00, 2'b00};
  logic m_out [2] = '{1'b0, 1'b0};
  bit m_imm [2] = '{0, 0};
  bit imm_v [2] = '{0, 0};
  int imm_val [2] = '{0, 0};

  always #2 clk = ~clk;

  pwm_aq_gen #(.W(W), .DIV_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_o(sync_o));

  function automatic logic b_act(logic cur, logic [1:0] c);
    case (c)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // step n running cycles, checking counter, outputs and sync each cycle
  task automatic step_chk(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int prev;
      bit s_exp;
      @(posedge clk);
      prev = m_cnt;
      for (int c = 0; c < 2; c++) begin
        if (prev == m_cmp[c])  m_out[c] = b_act(m_out[c], m_ca[c]);   // R3 compare first
        else if (prev == 0)    m_out[c] = b_act(m_out[c], m_za[c]);
      end
      s_exp = (prev == 0);
      if (prev == m_prd) begin
        m_cnt = 0; m_prd = m_prd_p; m_cmp[0] = m_cmp_p[0]; m_cmp[1] = m_cmp_p[1];
      end else m_cnt = prev + 1;
      for (int c = 0; c < 2; c++) if (imm_v[c]) begin m_cmp[c] = imm_val[c]; imm_v[c] = 0; end
      @(negedge clk);
      chk({tag, " R1 cnt"}, int'(cnt_o), m_cnt);
      chk({tag, " R2 pwm_a"}, int'(pwm_a), int'(m_out[0]));
      chk({tag, " R2 pwm_b"}, int'(pwm_b), int'(m_out[1]));
      chk({tag, " R7 sync"}, int'(sync_o), int'(s_exp));
    end
  endtask

  function automatic void note_wr(input int a, input int d);
    case (a)
      0: m_prd_p = d;
      1, 2: begin
        m_cmp_p[a-1] = d;
        if (m_imm[a-1]) begin imm_v[a-1] = 1; imm_val[a-1] = d; end
      end
      3, 4: begin m_za[a-3] = d[1:0]; m_ca[a-3] = d[3:2]; end
      5: begin m_imm[0] = d[0]; m_imm[1] = d[1]; end
      default: ;
    endcase
  endfunction

  // R10 register write while stopped
  task automatic cfg(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = W'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    note_wr(a, d);
    imm_v[0] = 0; imm_v[1] = 0;
  endtask

  // register write while running, checked across its cycle
  task automatic wr_run(input int a, input int d, input string tag);
    wr_en = 1; wr_addr = 3'(a); wr_data = W'(d);
    note_wr(a, d);
    step_chk(1, tag);
    wr_en = 0;
  endtask

  task automatic start_run();
    @(posedge clk); @(negedge clk);
    tb_en = 1;
    m_cnt = 0; m_prd = m_prd_p; m_cmp[0] = m_cmp_p[0]; m_cmp[1] = m_cmp_p[1];
  endtask

  // R6 stop: counter held at zero, outputs held, no sync
  task automatic t_stop();
    tb_en = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R6 stop cnt", int'(cnt_o), 0);
      chk("R6 stop pwm_a", int'(pwm_a), int'(m_out[0]));
      chk("R6 stop pwm_b", int'(pwm_b), int'(m_out[1]));
      chk("R6 stop sync", int'(sync_o), 0);
    end
  endtask

  task automatic t_reset();
    chk("R11 reset cnt", int'(cnt_o), 0);
    chk("R11 reset pwm_a", int'(pwm_a), 0);
    chk("R11 reset pwm_b", int'(pwm_b), 0);
    chk("R11 reset sync", int'(sync_o), 0);
    start_run();
    step_chk(4, "R11 reset regs");
    t_stop();
  endtask

  task automatic t_basic();
    cfg(0, 4); cfg(1, 2); cfg(2, 3);
    cfg(3, 4'b0110); cfg(4, 4'b0110);   // R10 zero=set, compare=clear
    start_run();
    step_chk(12, "R2 R10 basic");
    t_stop();
  endtask

  task automatic t_prio();
    cfg(1, 0); cfg(2, 0);
    cfg(4, 4'b1001);                   // B: zero=clear, compare=set
    start_run();
    step_chk(10, "R3 prio");
    t_stop();
  endtask

  task automatic t_over();
    cfg(3, 4'b0110); cfg(4, 4'b0110);
    cfg(1, 7); cfg(2, 4);
    start_run();
    step_chk(12, "R8 over");
    t_stop();
  endtask

  task automatic t_shadow();
    cfg(0, 4); cfg(1, 2); cfg(2, 3);
    start_run();
    step_chk(1, "R4 shadow");
    wr_run(1, 4, "R4 shadow cmp");
    step_chk(1, "R4 shadow");
    wr_run(0, 7, "R5 shadow prd");
    step_chk(18, "R5 R4 shadow");
    t_stop();
  endtask

  task automatic t_imm();
    cfg(5, 1); cfg(0, 9); cfg(1, 8);
    start_run();
    step_chk(2, "R4 imm");
    wr_run(1, 3, "R4 imm write");
    step_chk(12, "R4 imm");
    t_stop();
    cfg(5, 0);
  endtask

  task automatic t_toggle();
    cfg(0, 3); cfg(3, 4'b0011); cfg(4, 4'b0000);
    start_run();
    step_chk(14, "R2 toggle");
    t_stop();
  endtask

  task automatic t_prescale();
    cfg(0, 3); cfg(5, (1 << 2) | (1 << 4));
    start_run();
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 prescale cnt", int'(cnt_o), (k / 4) % 4);
    end
    tb_en = 0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prio();
    t_over();
    t_shadow();
    t_imm();
    t_toggle();
    t_prescale();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule